// File: doc/BRIEF.md
# Register-Programmable Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. The sense of each line is fixed when the block is built, through a two-bit code per line. A line can catch a rising edge, catch a falling edge, follow an active-high level or follow an active-low level. Every raw line passes through a two-flop synchronizer before detection. A detected event sets that line's bit in a sticky status word.

Software reaches the block through a plain synchronous register port: a word address, write data, a write strobe and registered read data. The port gives access to status, the enabled view of status, the enable mask, an acknowledge register, write-only aliases that set or clear mask bits without a read-modify-write, a vector register holding the number of the lowest enabled pending line, and a two-bit master control. Master bit 0 gates the output. Master bit 1 hands status over to the hardware lines. Once bit 1 is set it stays set until reset, and software can no longer set status bits.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, the output is low, and the vector register reads 0xFFFFFFFF.
- R2: Word address k selects byte offset 4k: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Bit n of each register is line n. The enable register is read/write, so writing 0 disables every line. Addresses 3, 4 and 5 read as 0. Read data appears one cycle after the address is presented.
- R3: A write to address 4 ORs the written mask into the enable register and leaves the other bits unchanged.
- R4: A write to address 5 clears the enable bits that are written as one and leaves the other bits unchanged.
- R5: Writing a one to a bit at address 3 clears that status bit. Writing all ones clears every status bit in one access.
- R6: The pending register reads as status AND enable. The vector register returns the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R7: The output rises one cycle after master bit 0 is set while any line is pending. It stays low while master bit 0 is 0.
- R8: The sense code for line n sits at parameter bits [2n+1:2n]: 0 catches a rising edge, 1 a falling edge, 2 a high level, 3 a low level. A qualifying edge or level sets the status bit.
- R9: Hardware events set status only while master bit 1 is 1. While master bit 1 is 0, a write to address 0 ORs bits into status. Once master bit 1 is 1, those writes have no effect, and writing master bit 1 as 0 does not clear it.
- R10: For a level-sensed line that is still asserted, a read of status right after the acknowledge shows the bit clear, and the next read shows it set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_in_i | input | N_IRQ | Raw interrupt request lines |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt output to the processor |

## Verification
The bench builds the block with N_IRQ = 8 and the sense parameter 16'hFA50. With these values, lines 0 and 1 catch rising edges, lines 2 and 3 catch falling edges, lines 4 and 5 follow a high level, and lines 6 and 7 follow a low level. This puts every sense variant of the generate block in one build. It also lets the bench check the re-set after acknowledge on a held level line next to edge lines that must stay clear. The narrow width also exercises the zero padding of the upper register bits and the all-ones vector value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned REG_W = 32;

   typedef enum logic [1:0] {
      SENSE_RISE = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_HIGH = 2'd2,
      SENSE_LOW  = 2'd3
   } sense_e;

   typedef enum logic [2:0] {
      RA_STAT   = 3'd0,
      RA_PEND   = 3'd1,
      RA_EN     = 3'd2,
      RA_ACK    = 3'd3,
      RA_SETEN  = 3'd4,
      RA_CLREN  = 3'd5,
      RA_VEC    = 3'd6,
      RA_MASTER = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
   parameter int unsigned        N_LINES = 32,
   parameter logic [2*N_LINES-1:0] SENSE = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_LINES-1:0] raw_i,
   output logic [N_LINES-1:0] event_o
);
   import irqc_pkg::*;

   logic [N_LINES-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= raw_i;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      localparam sense_e KIND = sense_e'(SENSE[2*i +: 2]);
      if (KIND == SENSE_RISE) begin : g_rise
         assign event_o[i] = sync_q[i] & ~prev_q[i];
      end else if (KIND == SENSE_FALL) begin : g_fall
         assign event_o[i] = ~sync_q[i] & prev_q[i];
      end else if (KIND == SENSE_HIGH) begin : g_high
         assign event_o[i] = sync_q[i];
      end else begin : g_low
         assign event_o[i] = ~sync_q[i];
      end
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int unsigned N_LINES = 32,
   localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic [N_LINES-1:0] pend_i,
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

   // R6: the chosen line is pending and no lower line is
   always_comb begin
      if (found_o) begin
         a_r6_vec_lowest : assert (pend_i[idx_o] &&
            ((pend_i & ((N_LINES'(1) << idx_o) - N_LINES'(1))) == '0));
      end else begin
         a_r6_vec_none : assert (pend_i == '0);
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int unsigned          N_IRQ = 32,
   parameter logic [2*N_IRQ-1:0]   SENSE = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_IRQ-1:0] irq_in_i,
   input  logic [2:0]       addr_i,
   input  logic [31:0]      wdata_i,
   input  logic             wr_i,
   output logic [31:0]      rdata_o,
   output logic             irq_o
);
   import irqc_pkg::*;

   localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

   if (N_IRQ < 1 || N_IRQ > REG_W) begin : g_bad_width
      $error("irq_ctrl: N_IRQ must lie between 1 and 32");
   end

   logic [N_IRQ-1:0] st_q, en_q, hw_ev, pend, wmask;
   logic             me_q, hie_q, irq_q;
   logic             found;
   logic [IDX_W-1:0] idx;
   logic [31:0]      rd_next, st_w, en_w, pend_w;

   irqc_detect #(.N_LINES(N_IRQ), .SENSE(SENSE)) i_detect (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (irq_in_i),
      .event_o (hw_ev)
   );

   assign wmask = wdata_i[N_IRQ-1:0];
   assign pend  = st_q & en_q;

   irqc_prio #(.N_LINES(N_IRQ)) i_prio (
      .pend_i  (pend),
      .found_o (found),
      .idx_o   (idx)
   );

   logic wr_stat, wr_ack, wr_en, wr_set, wr_clr, wr_mst;
   assign wr_stat = wr_i && (addr_i == RA_STAT);
   assign wr_ack  = wr_i && (addr_i == RA_ACK);
   assign wr_en   = wr_i && (addr_i == RA_EN);
   assign wr_set  = wr_i && (addr_i == RA_SETEN);
   assign wr_clr  = wr_i && (addr_i == RA_CLREN);
   assign wr_mst  = wr_i && (addr_i == RA_MASTER);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= '0;
         en_q  <= '0;
         me_q  <= 1'b0;
         hie_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         // acknowledge wins over a same-cycle set; a held level re-sets next cycle
         st_q <= (st_q
                  | (hie_q ? hw_ev : '0)
                  | ((wr_stat && !hie_q) ? wmask : '0))
                 & ~(wr_ack ? wmask : '0);
         if (wr_en)       en_q <= wmask;
         else if (wr_set) en_q <= en_q | wmask;
         else if (wr_clr) en_q <= en_q & ~wmask;
         if (wr_mst) begin
            me_q  <= wdata_i[0];
            hie_q <= hie_q | wdata_i[1];
         end
         irq_q <= me_q & (|pend);
      end
   end

   always_comb begin
      st_w   = '0;
      en_w   = '0;
      pend_w = '0;
      st_w[N_IRQ-1:0]   = st_q;
      en_w[N_IRQ-1:0]   = en_q;
      pend_w[N_IRQ-1:0] = pend;
      unique case (reg_addr_e'(addr_i))
         RA_STAT:   rd_next = st_w;
         RA_PEND:   rd_next = pend_w;
         RA_EN:     rd_next = en_w;
         RA_VEC:    rd_next = found ? 32'(idx) : '1;
         RA_MASTER: rd_next = {30'd0, hie_q, me_q};
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o <= '0;
      else         rdata_o <= rd_next;
   end

   assign irq_o = irq_q;

   // R3: set-enable leaves every written bit enabled
   a_r3_set_enable : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_set |=> ((en_q & $past(wmask)) == $past(wmask)));
   // R4: clear-enable leaves no written bit enabled
   a_r4_clear_enable : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_clr |=> ((en_q & $past(wmask)) == '0));
   // R5: acknowledged bits read clear in the following cycle
   a_r5_ack_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ack |=> ((st_q & $past(wmask)) == '0));
   // R7: output only follows a cycle with master bit 0 set
   a_r7_gated_output : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !me_q |=> !irq_o);
   // R9: hardware handover bit is sticky
   a_r9_hie_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      hie_q |=> hie_q);
   // R9: before handover nothing but a software write sets status
   a_r9_hw_blocked : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hie_q && !wr_stat) |=> ((st_q & ~$past(st_q)) == '0));
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
   localparam int unsigned N = 8;
   localparam logic [2*N-1:0] SNS = 16'hFA50;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = 8'hC0;
   logic [2:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic          wr = 1'b0;
   logic [31:0]   rdata;
   logic          irq;

   always #4 clk = ~clk;

   irq_ctrl #(.N_IRQ(N), .SENSE(SNS)) i_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .irq_in_i(irq_in), .addr_i(addr),
      .wdata_i(wdata), .wr_i(wr), .rdata_o(rdata), .irq_o(irq)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;

   int          q_cyc[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare registered read data one cycle after the request
   always @(negedge clk) begin
      if (q_cyc.size() > 0 && cyc == q_cyc[0] + 1) begin
         total++;
         if (rdata !== q_exp[0]) begin
            bad++;
            $display("FAIL %s: read got %h expected %h", q_tag[0], rdata, q_exp[0]);
         end
         void'(q_cyc.pop_front());
         void'(q_exp.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic push_rd(input logic [2:0] a, input logic [31:0] e, input string t);
      addr = a;
      q_cyc.push_back(cyc);
      q_exp.push_back(e);
      q_tag.push_back(t);
   endtask

   task automatic rd_reg(input logic [2:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      push_rd(a, e, t);
   endtask

   task automatic chk_irq(input logic e, input string t);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq got %b expected %b", t, irq, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run got hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_irq(1'b0, "R1");
      rd_reg(3'd0, 32'h0, "R1");
      rd_reg(3'd2, 32'h0, "R1");
      rd_reg(3'd7, 32'h0, "R1");
      rd_reg(3'd6, 32'hFFFF_FFFF, "R1");
      // R9: hardware edge ignored before handover
      irq_in[1] = 1'b1; idle(5); irq_in[1] = 1'b0; idle(5);
      rd_reg(3'd0, 32'h0, "R9");
      // R9: software may set status before handover
      wr_reg(3'd0, 32'h05);
      rd_reg(3'd0, 32'h05, "R9");
      rd_reg(3'd1, 32'h0, "R6");
      wr_reg(3'd2, 32'h0F);
      rd_reg(3'd2, 32'h0F, "R2");
      rd_reg(3'd1, 32'h05, "R6");
      rd_reg(3'd6, 32'h0, "R6");
      idle(3);
      chk_irq(1'b0, "R7");
      wr_reg(3'd7, 32'h1);
      idle(2);
      chk_irq(1'b1, "R7");
      wr_reg(3'd3, 32'h01);
      rd_reg(3'd6, 32'h2, "R5");
      wr_reg(3'd3, 32'hFFFF_FFFF);
      rd_reg(3'd0, 32'h0, "R5");
      idle(2);
      chk_irq(1'b0, "R7");
      // R3 / R4 / R2 mask handling
      wr_reg(3'd4, 32'h30);
      rd_reg(3'd2, 32'h3F, "R3");
      wr_reg(3'd5, 32'h05);
      rd_reg(3'd2, 32'h3A, "R4");
      wr_reg(3'd2, 32'h0);
      rd_reg(3'd2, 32'h0, "R2");
      rd_reg(3'd3, 32'h0, "R2");
      rd_reg(3'd4, 32'h0, "R2");
      rd_reg(3'd5, 32'h0, "R2");
      // R9 handover and stickiness
      wr_reg(3'd7, 32'h3);
      wr_reg(3'd7, 32'h0);
      rd_reg(3'd7, 32'h2, "R9");
      wr_reg(3'd0, 32'hFF);
      rd_reg(3'd0, 32'h0, "R9");
      wr_reg(3'd7, 32'h3);
      wr_reg(3'd2, 32'hFF);
      // R8 rising edge on line 0
      irq_in[0] = 1'b1; idle(5);
      rd_reg(3'd0, 32'h01, "R8");
      wr_reg(3'd3, 32'h01); idle(4);
      rd_reg(3'd0, 32'h0, "R8");
      irq_in[0] = 1'b0; idle(5);
      rd_reg(3'd0, 32'h0, "R8");
      // R8 falling edge on line 2
      irq_in[2] = 1'b1; idle(5);
      rd_reg(3'd0, 32'h0, "R8");
      irq_in[2] = 1'b0; idle(5);
      rd_reg(3'd0, 32'h04, "R8");
      wr_reg(3'd3, 32'h04);
      // R8 / R10 high level on line 4
      irq_in[4] = 1'b1; idle(5);
      rd_reg(3'd0, 32'h10, "R8");
      @(negedge clk);
      addr = 3'd3; wdata = 32'h10; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      push_rd(3'd0, 32'h0, "R10");
      rd_reg(3'd0, 32'h10, "R10");
      irq_in[4] = 1'b0; idle(4);
      wr_reg(3'd3, 32'h10); idle(2);
      rd_reg(3'd0, 32'h0, "R8");
      // R8 low level on line 6
      irq_in[6] = 1'b0; idle(5);
      rd_reg(3'd0, 32'h40, "R8");
      irq_in[6] = 1'b1; idle(4);
      wr_reg(3'd3, 32'h40); idle(2);
      rd_reg(3'd0, 32'h0, "R8");
      // R6 vector ordering with hardware lines 1 and 5
      irq_in[5] = 1'b1; irq_in[1] = 1'b1; idle(5);
      rd_reg(3'd6, 32'h1, "R6");
      idle(1);
      chk_irq(1'b1, "R7");
      wr_reg(3'd3, 32'h02);
      rd_reg(3'd6, 32'h5, "R6");
      wr_reg(3'd5, 32'h20);
      rd_reg(3'd6, 32'hFFFF_FFFF, "R6");
      rd_reg(3'd1, 32'h0, "R6");
      idle(3);
      chk_irq(1'b0, "R7");
      idle(3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule